// File: doc/BRIEF.md
# Byte-to-Serial Configuration Clock Generator

This block sits in the first device of a configuration chain. It accepts whole bytes and sends them out one bit at a time on a serial data pin. It also drives the serial clock that it and every downstream device use. The serial clock comes from the system clock through a parameterised divider. It stays low whenever no byte is being sent. Each byte is sent most significant bit first. The data pin changes only while the clock is low, so a downstream device samples it on the rising clock edge.

Bytes come from one of two sources, selected by a mode pin. In memory-fetch mode the block runs its own address counter. It starts at address zero, reads the byte the memory presents at the current address, and emits eight serial clocks for it. After the eighth bit it advances the address by one, which gives a serial clock rate of eight times the address rate. A stop input halts fetching between bytes. In host-write mode, a cycle with both chip-select and write-strobe high starts one burst of exactly eight serial clocks for the byte on the host data bus. The host port applies no back-pressure: `busy_o` plays the role of an inverted ready. A write that arrives while `busy_o` is high is dropped and is not held for later, so the host must wait for `busy_o` low before writing again. The memory must present the data for `mem_addr_o` combinationally within the same cycle.

Top module: `cfg_serializer`

## Requirements
- R1: After reset, `cclk_o`, `dout_o` and `busy_o` are low and `mem_addr_o` is zero.
- R2: Every accepted byte produces exactly eight rising edges of `cclk_o`, and `cclk_o` is low whenever `busy_o` is low.
- R3: The bits of a byte appear on `dout_o` most significant bit first; bit 7 is the value at the first rising edge of the burst.
- R4: `dout_o` changes only in the same system cycle that `cclk_o` falls, or in the cycle a new byte is loaded while `cclk_o` is low; it is therefore stable at every rising edge of `cclk_o`.
- R5: Each high phase and each low phase of `cclk_o` within a burst lasts `HALF_CYC` system clock cycles, so consecutive rising edges within a burst are 2*`HALF_CYC` cycles apart.
- R6: In host-write mode (`mode_i` = 1), a cycle with `host_cs_i` and `host_wr_i` both high while `busy_o` is low loads `host_data_i`. `busy_o` goes high at the next clock edge and stays high until the eighth falling edge of `cclk_o`.
- R7: A host write that arrives while `busy_o` is high is ignored; it produces no serial clocks and no data.
- R8: In memory-fetch mode (`mode_i` = 0), bytes are read from addresses 0, 1, 2, ... in order. `mem_addr_o` increases by exactly one after the eighth bit of each byte and never changes otherwise, which gives eight serial clocks per address.
- R9: In memory-fetch mode, while `stop_i` is high between bytes, no new byte starts, `cclk_o` stays low and `mem_addr_o` holds.
- R10: A cycle with only one of `host_cs_i` and `host_wr_i` high starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Byte source: 0 memory-fetch, 1 host-write; sampled when idle |
| stop_i | input | 1 | Halts memory fetching between bytes |
| mem_addr_o | output | ADDR_W | Address of the next byte to fetch |
| mem_data_i | input | 8 | Byte stored at `mem_addr_o` |
| host_cs_i | input | 1 | Host chip-select |
| host_wr_i | input | 1 | Host write-strobe |
| host_data_i | input | 8 | Host byte to send |
| busy_o | output | 1 | High while a byte is being shifted out |
| cclk_o | output | 1 | Serial configuration clock for this and downstream devices |
| dout_o | output | 1 | Serial data, changed while `cclk_o` is low |

## Verification
A corrupted bit counter would show within one byte: a burst of seven or nine rising edges on `cclk_o`, or a byte that reaches the scoreboard misaligned with the expected one. A wrong divider phase shows at the next rising edge as a spacing other than 2*`HALF_CYC` cycles. A stuck state register shows as `busy_o` that never falls, or a host write that is accepted during a burst, in which case an unexpected byte appears. A faulty address counter shows at the end of the first fetched byte as a skipped or repeated memory byte in the serial stream.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
  localparam int unsigned BITS_PER_BYTE = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } ser_state_e;

  typedef enum logic {
    SRC_MEMORY = 1'b0,
    SRC_HOST   = 1'b1
  } ser_src_e;
endpackage

// File: rtl/cfgser_clkgen.sv
module cfgser_clkgen #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic cclk_o,
  output logic fall_tick_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] PH_LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] ph_q;
  logic          cclk_q;
  logic          ph_end;

  assign ph_end = (ph_q == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      cclk_q <= 1'b0;
    end else if (!run_i) begin
      ph_q   <= '0;
      cclk_q <= 1'b0;
    end else if (ph_end) begin
      ph_q   <= '0;
      cclk_q <= ~cclk_q;
    end else begin
      ph_q <= ph_q + CW'(1);
    end
  end

  assign cclk_o      = cclk_q;
  assign fall_tick_o = run_i & ph_end & cclk_q;

  generate
    if (HALF_CYC > 1) begin : g_phase_chk
      // R5: a freshly risen clock holds high for more than one cycle
      a_r5_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_q) |=> cclk_q);
      // R5: a freshly fallen clock within a run holds low for more than one cycle
      a_r5_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cclk_q) && run_i) |=> !cclk_q);
    end
  endgenerate
endmodule

// File: rtl/cfgser_shifter.sv
module cfgser_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         dout_o,
  output logic         last_o
);
  localparam int unsigned CNTW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(W - 1);

  logic [W-1:0]    sreg_q;
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      sreg_q <= data_i;
      cnt_q  <= '0;
    end else if (shift_i) begin
      sreg_q <= {sreg_q[W-2:0], 1'b0};
      cnt_q  <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CNTW'(1);
    end
  end

  assign dout_o = sreg_q[W-1];
  assign last_o = (cnt_q == CNT_LAST);

  // R3: the top bit of a loaded byte is presented first
  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (dout_o == $past(data_i[W-1])));
endmodule

// File: rtl/cfgser_addrgen.sv
module cfgser_addrgen #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (inc_i) addr_q <= addr_q + AW'(1);
  end

  assign addr_o = addr_q;

  // R8: the address only ever moves forward by one
  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> (addr_q == $past(addr_q) + AW'(1)));
endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer
  import cfgser_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned HALF_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_i,
  input  logic                     stop_i,
  output logic [ADDR_W-1:0]        mem_addr_o,
  input  logic [BITS_PER_BYTE-1:0] mem_data_i,
  input  logic                     host_cs_i,
  input  logic                     host_wr_i,
  input  logic [BITS_PER_BYTE-1:0] host_data_i,
  output logic                     busy_o,
  output logic                     cclk_o,
  output logic                     dout_o
);
  localparam int unsigned BW = BITS_PER_BYTE;

  ser_state_e      state_q;
  ser_src_e        src_q;
  logic            host_fire;
  logic            start_mem;
  logic            start_host;
  logic            load;
  logic [BW-1:0]   load_data;
  logic            fall_tick;
  logic            last_bit;
  logic            byte_done;
  logic            running;

  assign host_fire  = host_cs_i & host_wr_i;
  assign start_mem  = (state_q == ST_IDLE) && (mode_i == SRC_MEMORY) && !stop_i;
  assign start_host = (state_q == ST_IDLE) && (mode_i == SRC_HOST) && host_fire;
  assign load       = start_mem | start_host;
  assign load_data  = start_mem ? mem_data_i : host_data_i;
  assign running    = (state_q == ST_SEND);
  assign byte_done  = running && fall_tick && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= SRC_MEMORY;
    end else begin
      case (state_q)
        ST_IDLE: if (load) begin
          state_q <= ST_SEND;
          src_q   <= start_mem ? SRC_MEMORY : SRC_HOST;
        end
        ST_SEND: if (byte_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  cfgser_clkgen #(.HALF_CYC(HALF_CYC)) u_clkgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (running),
    .cclk_o      (cclk_o),
    .fall_tick_o (fall_tick)
  );

  cfgser_shifter #(.W(BW)) u_shifter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .data_i  (load_data),
    .shift_i (fall_tick),
    .dout_o  (dout_o),
    .last_o  (last_bit)
  );

  cfgser_addrgen #(.AW(ADDR_W)) u_addrgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (byte_done && (src_q == SRC_MEMORY)),
    .addr_o (mem_addr_o)
  );

  assign busy_o = running;

  // R2: the serial clock idles low outside a burst
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cclk_o);
  // R4: data moves only on a falling clock or at a byte load
  a_r4_dout_timing: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_o) |-> ($fell(cclk_o) || $rose(busy_o)));
  // R6: a started burst keeps busy for more than one cycle
  a_r6_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> busy_o);
  // R9: stop between fetched bytes keeps the block idle
  a_r9_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && stop_i && (mode_i == SRC_MEMORY)) |=> !busy_o);
endmodule

// File: tb/cfg_serializer_bench.sv
module cfg_serializer_bench;
  localparam int unsigned AW   = 16;
  localparam int unsigned HALF = 2;
  localparam int unsigned NMEM = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_i = 1'b1;
  logic          stop_i = 1'b1;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_data_i;
  logic          host_cs_i = 1'b0;
  logic          host_wr_i = 1'b0;
  logic [7:0]    host_data_i = 8'h00;
  logic          busy_o;
  logic          cclk_o;
  logic          dout_o;

  int checks = 0;
  int fails  = 0;
  int rises  = 0;
  int pushed = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return 8'(a * 29 + 7);
  endfunction

  assign mem_data_i = mem_byte(mem_addr_o);

  cfg_serializer #(.ADDR_W(AW), .HALF_CYC(HALF)) u_cfg_serializer (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .stop_i(stop_i),
    .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .host_cs_i(host_cs_i), .host_wr_i(host_wr_i), .host_data_i(host_data_i),
    .busy_o(busy_o), .cclk_o(cclk_o), .dout_o(dout_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: rebuild bytes from dout sampled at each cclk rise
  logic       prev_cclk = 1'b0;
  logic [7:0] shreg = 8'h00;
  int         nbits = 0;
  int         last_rise = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && cclk_o && !prev_cclk) begin
      rises++;
      if (nbits > 0)
        check(cyc - last_rise == 2 * HALF, "R5 rise spacing", cyc - last_rise, 2 * HALF);
      last_rise = cyc;
      shreg = {shreg[6:0], dout_o};
      nbits++;
      if (nbits == 8) begin
        nbits = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected byte", shreg, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(shreg == e, t, shreg, e);
        end
      end
    end
    prev_cclk = cclk_o;
  end

  task automatic host_write(input logic [7:0] d, input bit expect_accept);
    @(negedge clk);
    host_data_i = d;
    host_cs_i = 1'b1;
    host_wr_i = 1'b1;
    if (expect_accept) begin
      exp_q.push_back(d);
      tag_q.push_back("R3/R6 host byte");
      pushed++;
    end
    @(negedge clk);
    host_cs_i = 1'b0;
    host_wr_i = 1'b0;
    if (expect_accept) check(busy_o == 1'b1, "R6 busy after write", busy_o, 1);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cclk_o == 1'b0, "R1 cclk reset", cclk_o, 0);
    check(dout_o == 1'b0, "R1 dout reset", dout_o, 0);
    check(busy_o == 1'b0, "R1 busy reset", busy_o, 0);
    check(mem_addr_o == '0, "R1 addr reset", int'(mem_addr_o), 0);

    // R10: one strobe alone starts nothing
    host_cs_i = 1'b1; @(negedge clk); host_cs_i = 1'b0;
    host_wr_i = 1'b1; @(negedge clk); host_wr_i = 1'b0;
    repeat (20) @(negedge clk);
    check(rises == 0, "R10 no clocks", rises, 0);
    check(busy_o == 1'b0, "R10 stays idle", busy_o, 0);

    // R6 / R3: host bytes
    host_write(8'hA5, 1'b1); wait_idle();
    host_write(8'h3C, 1'b1); wait_idle();
    host_write(8'h81, 1'b1); wait_idle();
    host_write(8'h7E, 1'b1); wait_idle();
    check(cclk_o == 1'b0, "R2 idle low", cclk_o, 0);

    // R7: write during a burst is dropped
    host_write(8'h5A, 1'b1);
    repeat (6) @(negedge clk);
    host_write(8'hFF, 1'b0);
    wait_idle();
    repeat (30) @(negedge clk);
    check(rises == 8 * pushed, "R7 no extra clocks", rises, 8 * pushed);
    host_write(8'h00, 1'b1); wait_idle();

    // R9: memory mode held by stop
    mode_i = 1'b0;
    repeat (12) @(negedge clk);
    check(busy_o == 1'b0, "R9 stop holds idle", busy_o, 0);
    check(mem_addr_o == '0, "R9 addr held", int'(mem_addr_o), 0);
    check(rises == 8 * pushed, "R9 no clocks", rises, 8 * pushed);

    // R8: fetched bytes in address order
    for (int k = 0; k < NMEM; k++) begin
      exp_q.push_back(mem_byte(AW'(k)));
      tag_q.push_back("R8/R3 memory byte");
      pushed++;
    end
    stop_i = 1'b0;
    while (mem_addr_o != AW'(NMEM)) @(negedge clk);
    stop_i = 1'b1;
    repeat (30) @(negedge clk);
    check(mem_addr_o == AW'(NMEM), "R8 final addr", int'(mem_addr_o), NMEM);
    check(busy_o == 1'b0, "R9 stopped", busy_o, 0);
    check(exp_q.size() == 0, "R8 all bytes seen", exp_q.size(), 0);
    check(rises == 8 * pushed, "R2 eight clocks per byte", rises, 8 * pushed);
    check(cclk_o == 1'b0, "R2 idle low after fetch", cclk_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule